// File: doc/BRIEF.md
# Multi-Valued Peak-Hold Symbol Shift Register

This block stores and moves symbols of an R-valued logic system. Each symbol is a level from 0 to R-1. It is carried as an unsigned binary code of ceil(log2 R) bits whose numeric value is the level. The block is a chain of stages. Each stage is one master-slave register clocked by the rising edge of a single clock, so every clock edge moves data forward by one stage.

A parameter mask sets the mode of each stage. A plain stage loads the value of the stage before it. A peak stage instead combines its own stored level with the incoming level through a MAX gate. It then limits the result through a MIN gate against a shared cap level. While the cap is at R-1 a peak stage keeps the highest level it has seen. Driving the cap to 0 empties it.

Any code of R or above, on the data input or on the cap input, is quantised down to R-1 before use. A synchronous reset and a synchronous global clear both drive every stage to level 0. A host uses the block as a delay line for R-valued symbols with optional peak detectors placed along it.

Top module: `mv_peak_chain`

## Requirements
- R1: When `rst` is high at a rising edge, every stage holds level 0 after that edge.
- R2: When `clr` is high at a rising edge (and `rst` low), every stage holds level 0 after that edge, whatever the data and cap inputs are.
- R3: A `din` code of RADIX or above enters the chain as level RADIX-1. A code below RADIX enters unchanged. Codes are unsigned binary level values.
- R4: A plain stage takes, at each rising edge, the level the stage before it held just before the edge. Stage 0 takes the quantised `din`. Plain stages therefore delay data by one cycle each.
- R5: A peak stage's next level is MIN(MAX(own level, incoming level), quantised cap).
- R6: With the cap at level RADIX-1, a peak stage never decreases and follows the highest incoming level since it was last emptied.
- R7: With the cap at level 0, a peak stage holds level 0 after the edge.
- R8: A `cap_lvl` code of RADIX or above acts as level RADIX-1.
- R9: Every stage holds a legal level, below RADIX, at all times after reset.
- R10: `dout` equals the level of the last stage. `taps` carries stage i on bits [i*SYM_W +: SYM_W].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Two-valued clock; rising edge moves the chain |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous global clear to level 0 |
| din | input | SYM_W | Incoming symbol code |
| cap_lvl | input | SYM_W | Cap level applied through MIN in peak stages |
| taps | output | STAGES*SYM_W | Levels of all stages, stage 0 in the low bits |
| dout | output | SYM_W | Level of the last stage |

## Verification
The bench builds the block with RADIX 5 on 3-bit codes and four stages. The last stage is peak-mode and the others are plain. Three of the eight codes are illegal, so the quantising path is exercised. A full sweep of every cap code against every data code fits in 64 cycles and covers all combinations of plain delay, clamping, peak tracking, capping and emptying. Random five-valued streams with interleaved clears and resets then test delay and data integrity against a model computed arithmetically in the bench.

// File: rtl/mv_peak_pkg.sv
package mv_peak_pkg;

    typedef enum logic {
        STG_PLAIN = 1'b0,
        STG_PEAK  = 1'b1
    } stage_mode_e;

    // R-valued OR is the larger level
    function automatic int unsigned lvl_or(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // R-valued AND is the smaller level
    function automatic int unsigned lvl_and(int unsigned a, int unsigned b);
        return (a < b) ? a : b;
    endfunction

    // Quantising restore: anything above the top level lands on it
    function automatic int unsigned lvl_restore(int unsigned v, int unsigned radix);
        return (v >= radix) ? radix - 1 : v;
    endfunction

endpackage

// File: rtl/mv_restore.sv
module mv_restore #(
    parameter int RADIX = 5,
    parameter int SYM_W = $clog2(RADIX)
) (
    input  logic [SYM_W-1:0] code_in,
    output logic [SYM_W-1:0] level_out
);
    import mv_peak_pkg::*;

    always_comb begin
        level_out = SYM_W'(lvl_restore(32'(code_in), RADIX));
    end
endmodule

// File: rtl/mv_plain_cell.sv
module mv_plain_cell #(
    parameter int SYM_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [SYM_W-1:0] lvl_in,
    output logic [SYM_W-1:0] lvl_q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_in;
        end
    end
endmodule

// File: rtl/mv_peak_cell.sv
module mv_peak_cell #(
    parameter int SYM_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [SYM_W-1:0] lvl_in,
    input  logic [SYM_W-1:0] cap_in,
    output logic [SYM_W-1:0] lvl_q
);
    import mv_peak_pkg::*;

    logic [SYM_W-1:0] gated;

    // MAX with the stored level, then MIN against the cap
    always_comb begin
        gated = SYM_W'(lvl_and(lvl_or(32'(lvl_q), 32'(lvl_in)), 32'(cap_in)));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= gated;
        end
    end
endmodule

// File: rtl/mv_peak_chain.sv
module mv_peak_chain #(
    parameter int                RADIX     = 5,
    parameter int                STAGES    = 8,
    parameter logic [STAGES-1:0] HOLD_MASK = '0,
    parameter int                SYM_W     = $clog2(RADIX)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic [SYM_W-1:0]        din,
    input  logic [SYM_W-1:0]        cap_lvl,
    output logic [STAGES*SYM_W-1:0] taps,
    output logic [SYM_W-1:0]        dout
);
    import mv_peak_pkg::*;

    localparam int LAST = STAGES - 1;

    logic [SYM_W-1:0] din_lvl;
    logic [SYM_W-1:0] cap_q;
    logic [SYM_W-1:0] stage_in [STAGES];
    logic [SYM_W-1:0] stage_q  [STAGES];

    mv_restore #(.RADIX(RADIX), .SYM_W(SYM_W)) u_din_restore (
        .code_in  (din),
        .level_out(din_lvl)
    );

    mv_restore #(.RADIX(RADIX), .SYM_W(SYM_W)) u_cap_restore (
        .code_in  (cap_lvl),
        .level_out(cap_q)
    );

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            localparam stage_mode_e MODE = HOLD_MASK[i] ? STG_PEAK : STG_PLAIN;

            if (i == 0) begin : g_head
                assign stage_in[i] = din_lvl;
            end else begin : g_link
                assign stage_in[i] = stage_q[i-1];
            end

            if (MODE == STG_PEAK) begin : g_peak
                mv_peak_cell #(.SYM_W(SYM_W)) u_cell (
                    .clk   (clk),
                    .rst   (rst),
                    .clr   (clr),
                    .lvl_in(stage_in[i]),
                    .cap_in(cap_q),
                    .lvl_q (stage_q[i])
                );
            end else begin : g_plain
                mv_plain_cell #(.SYM_W(SYM_W)) u_cell (
                    .clk   (clk),
                    .rst   (rst),
                    .clr   (clr),
                    .lvl_in(stage_in[i]),
                    .lvl_q (stage_q[i])
                );
            end

            assign taps[i*SYM_W +: SYM_W] = stage_q[i];
        end
    endgenerate

    assign dout = stage_q[LAST];
endmodule

// File: rtl/mv_peak_chain_chk.sv
module mv_peak_chain_chk #(
    parameter int                RADIX     = 5,
    parameter int                STAGES    = 8,
    parameter logic [STAGES-1:0] HOLD_MASK = '0,
    parameter int                SYM_W     = $clog2(RADIX)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    clr,
    input logic [SYM_W-1:0]        din,
    input logic [SYM_W-1:0]        cap_lvl,
    input logic [STAGES*SYM_W-1:0] taps
);
    localparam logic [SYM_W-1:0] TOP = SYM_W'(RADIX - 1);

    p_rst_zero_r1: assert property (@(posedge clk) rst |=> (taps == '0));

    p_clr_zero_r2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (taps == '0));

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_chk
            p_legal_r9: assert property (@(posedge clk) disable iff (rst)
                taps[i*SYM_W +: SYM_W] <= TOP);

            if (HOLD_MASK[i]) begin : g_peak
                p_monotonic_r6: assert property (@(posedge clk) disable iff (rst)
                    (!clr && cap_lvl >= TOP) |=>
                    (taps[i*SYM_W +: SYM_W] >= $past(taps[i*SYM_W +: SYM_W])));
                p_capped_r5: assert property (@(posedge clk) disable iff (rst)
                    (!clr && cap_lvl < TOP) |=>
                    (taps[i*SYM_W +: SYM_W] <= $past(cap_lvl)));
                p_empty_r7: assert property (@(posedge clk) disable iff (rst)
                    (!clr && cap_lvl == '0) |=> (taps[i*SYM_W +: SYM_W] == '0));
            end else if (i == 0) begin : g_head
                p_clamp_r3: assert property (@(posedge clk) disable iff (rst)
                    (!clr && din >= TOP) |=> (taps[SYM_W-1:0] == TOP));
                p_pass_r3: assert property (@(posedge clk) disable iff (rst)
                    (!clr && din < TOP) |=> (taps[SYM_W-1:0] == $past(din)));
            end else begin : g_plain
                p_shift_r4: assert property (@(posedge clk) disable iff (rst)
                    !clr |=> (taps[i*SYM_W +: SYM_W] == $past(taps[(i-1)*SYM_W +: SYM_W])));
            end
        end
    endgenerate
endmodule

bind mv_peak_chain mv_peak_chain_chk #(
    .RADIX    (RADIX),
    .STAGES   (STAGES),
    .HOLD_MASK(HOLD_MASK),
    .SYM_W    (SYM_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .din    (din),
    .cap_lvl(cap_lvl),
    .taps   (taps)
);

// File: tb/mv_peak_chain_test.sv
`timescale 1ns/1ps
module mv_peak_chain_test;
    localparam int RADIX = 5;
    localparam int STAGES = 4;
    localparam int SYM_W = 3;
    localparam logic [STAGES-1:0] MASK = 4'b1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic [SYM_W-1:0] din = '0;
    logic [SYM_W-1:0] cap_lvl = '0;
    logic [STAGES*SYM_W-1:0] taps;
    logic [SYM_W-1:0] dout;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    int exp_q [STAGES];

    always #4 clk = ~clk;

    mv_peak_chain #(.RADIX(RADIX), .STAGES(STAGES), .HOLD_MASK(MASK), .SYM_W(SYM_W)) uut (
        .clk(clk), .rst(rst), .clr(clr), .din(din), .cap_lvl(cap_lvl),
        .taps(taps), .dout(dout)
    );

    function automatic int quant(int v);
        return (v >= RADIX) ? RADIX - 1 : v;
    endfunction

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive at the falling edge, advance one rising edge, compare at the next falling edge
    task automatic step(int d, int c, bit cl, bit r, string head_tag, string peak_tag);
        int nxt [STAGES];
        din = SYM_W'(d);
        cap_lvl = SYM_W'(c);
        clr = cl;
        rst = r;
        if (r || cl) begin
            foreach (nxt[k]) nxt[k] = 0;
        end else begin
            nxt[0] = quant(d);
            nxt[1] = exp_q[0];
            nxt[2] = exp_q[1];
            nxt[3] = exp_q[3] > exp_q[2] ? exp_q[3] : exp_q[2];
            if (nxt[3] > quant(c)) nxt[3] = quant(c);
        end
        foreach (nxt[k]) exp_q[k] = nxt[k];
        @(posedge clk);
        @(negedge clk);
        check(head_tag, int'(taps[SYM_W-1:0]), exp_q[0]);
        check(r ? "R1" : (cl ? "R2" : "R4"), int'(taps[SYM_W +: SYM_W]), exp_q[1]);
        check(r ? "R1" : (cl ? "R2" : "R4"), int'(taps[2*SYM_W +: SYM_W]), exp_q[2]);
        check(peak_tag, int'(taps[3*SYM_W +: SYM_W]), exp_q[3]);
        check("R10", int'(dout), exp_q[3]);
        for (int k = 0; k < STAGES; k++) begin
            if (!(int'(taps[k*SYM_W +: SYM_W]) < RADIX)) check("R9", int'(taps[k*SYM_W +: SYM_W]), RADIX - 1);
            else compared++;
        end
    endtask

    function automatic string peak_tag_of(int c, bit cl, bit r);
        if (r) return "R1";
        if (cl) return "R2";
        if (c == 0) return "R7";
        if (c >= RADIX) return "R8";
        if (c == RADIX - 1) return "R6";
        return "R5";
    endfunction

    initial begin
        foreach (exp_q[k]) exp_q[k] = 0;
        @(negedge clk);
        // R1: reset state
        step(3, 4, 1'b0, 1'b1, "R1", "R1");
        step(7, 7, 1'b0, 1'b1, "R1", "R1");
        // Exhaustive sweep: every cap code against every data code (R3 R5 R6 R7 R8)
        for (int c = 0; c < 8; c++) begin
            for (int d = 0; d < 8; d++) begin
                step((d * 3 + c) % 8, c, 1'b0, 1'b0, "R3", peak_tag_of(c, 1'b0, 1'b0));
            end
        end
        // R6: rising then falling levels under open cap, peak must stay
        for (int d = 0; d < RADIX; d++) step(d, RADIX - 1, 1'b0, 1'b0, "R3", "R6");
        for (int d = RADIX - 1; d >= 0; d--) step(d, 7, 1'b0, 1'b0, "R3", "R8");
        // R7: cap at 0 empties the peak stage
        step(2, 0, 1'b0, 1'b0, "R3", "R7");
        // R2: global clear with data present
        step(4, 4, 1'b0, 1'b0, "R3", "R6");
        step(4, 4, 1'b1, 1'b0, "R2", "R2");
        // Random five-valued streams with occasional clears, resets and caps
        for (int n = 0; n < 600; n++) begin
            int d, c, sel;
            bit cl, r;
            sel = $urandom_range(0, 99);
            d = $urandom_range(0, 7);
            c = (sel < 70) ? RADIX - 1 : $urandom_range(0, 7);
            cl = (sel == 97);
            r = (sel == 98);
            step(d, c, cl, r, r ? "R1" : (cl ? "R2" : "R3"), peak_tag_of(c, cl, r));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            mismatched++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule